// File: doc/BRIEF.md
# SAR converter control core

This block is the digital side of a 12-bit successive-approximation converter. It decides when a conversion begins, steps a trial code through the result bits from the most significant bit down, and latches the finished word. It also drives a parallel data port that can present the word either whole or folded for an 8-bit reader. The analog comparator appears only as a single decision input, `cmp_keep`. The trial code the comparator would judge is brought out on `trial_code`, so that a model of the analog input can answer each trial. The pads of the data port are three-state; here they are modelled as a data vector plus an enable.

A host starts a conversion by pulling chip select and read low together while the high-byte select is low. The block answers by taking `busy_n` low. It releases `busy_n` in the same cycle that the new word lands in the result latch. Any read before that returns the previous word. With the high-byte select raised, the upper four result bits are copied onto the lowest four pins, so an 8-bit bus can fetch the word in two reads. Raising the high-byte select also blocks a start.

Top module: `sar_adc_core`

## Requirements
- R1: A conversion starts only on the clock edge at which the condition (cs_n low, rd_n low and hbyte_sel low) is first seen true after having been false. A condition held true after a conversion ends does not start another one, and a condition with only some of the three inputs low starts nothing.
- R2: While a conversion is running, a fresh start condition is ignored. The running conversion keeps its length and its result.
- R3: busy_n goes low on the start edge and stays low for exactly 13 clock cycles (one lead cycle plus one cycle per bit). It returns high on the same edge that loads the result latch.
- R4: On the start edge the register is cleared and trial_code becomes 12'h800. Bit 11 is decided on the second clock edge after the start edge, and each lower bit on the edge after that. trial_code shows the bits decided so far with the next trial bit set, and reads zero when idle.
- R5: cmp_keep, sampled on the deciding edge, keeps the trial bit when 1 and drops it when 0. With a comparator that answers (input code >= trial_code), the latched result equals the input code in natural binary, including 0 and 12'hFFF.
- R6: data_oe is 1 exactly when cs_n and rd_n are both low.
- R7: Until a conversion completes, data_out presents the previously latched word.
- R8: With hbyte_sel low, data_out[11:0] equals result bits 11..0.
- R9: With hbyte_sel high, data_out[11:8] and data_out[3:0] both carry result bits 11..8, data_out[7:4] are 0, and no conversion can start.
- R10: clk_out is always the logical inverse of clk_in.
- R11: After the synchronous active-low reset, the result latch holds zero, busy_n is high and no conversion is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hbyte_sel | input | 1 | High-byte select; high folds the upper bits down and blocks starts |
| cmp_keep | input | 1 | Comparator decision for the current trial bit, 1 = keep |
| clk_out | output | 1 | Inverted conversion clock |
| busy_n | output | 1 | Low while a conversion runs |
| trial_code | output | 12 | Code under trial, presented to the comparator model |
| data_out | output | 12 | Data port value |
| data_oe | output | 1 | Data port drive enable |

## Verification
The bench builds the block with its defaults: 12 result bits, one lead cycle and an 8-bit low byte. That makes the conversion window 13 cycles, and the fold moves exactly four upper bits onto the four lowest pins with a four-pin zero gap between them. These values make the bench's expected counts and pin patterns exact. Input codes at both ends of the range and codes on either side of the MSB threshold can then be converted and compared against the result read back. The high-byte-to-low transition while selected also creates a start edge, so a start during a read sequence is exercised.

// File: rtl/sar_adc_pkg.sv
// Package: shared types for the SAR converter control core.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sar_adc_pkg;

    // Sequencer phases: idle, lead-in before the first decision, bit resolution.
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_LEAD    = 2'd1,
        SEQ_RESOLVE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/sar_start_gate.sv
// Module: sar_start_gate
// Builds the start pulse from the three active-low control inputs.
// The start is edge triggered: a pulse is produced only on the first clock
// edge at which all three are low, and only while the sequencer is idle.
// Assumes the inputs are already synchronous to clk.
module sar_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic hbyte_sel,
    input  logic idle,
    output logic start
);

    logic cond;
    logic cond_q;

    // Purpose: the combined start condition.
    always_comb cond = ~cs_n & ~rd_n & ~hbyte_sel;

    // Purpose: remember last condition; reset high so a held level is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b1;
        else        cond_q <= cond;
    end

    // Purpose: rising edge of the condition, gated by the idle lockout.
    always_comb start = cond & ~cond_q & idle;

endmodule

// File: rtl/sar_sequencer.sv
// Module: sar_sequencer
// Runs one successive-approximation conversion per start pulse: clears the
// register, waits LEAD_CYCLES, then decides one bit per clock from the MSB
// down, and loads the result latch on the edge that decides the LSB.
// Assumes LEAD_CYCLES >= 1 and that start arrives only while idle.
module sar_sequencer
    import sar_adc_pkg::*;
#(
    parameter  int RES_BITS    = 12,
    parameter  int LEAD_CYCLES = 1,
    localparam int IDX_W       = $clog2(RES_BITS),
    localparam int LEAD_W      = $clog2(LEAD_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cmp_keep,
    output logic                busy_n,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] result_q
);

    localparam logic [IDX_W-1:0]  TOP_IDX   = IDX_W'(RES_BITS - 1);
    localparam logic [LEAD_W-1:0] LEAD_LOAD = LEAD_W'(LEAD_CYCLES - 1);

    seq_state_t          state_q;
    logic [IDX_W-1:0]    bit_idx_q;
    logic [LEAD_W-1:0]   lead_cnt_q;
    logic [RES_BITS-1:0] sar_q;
    logic [RES_BITS-1:0] trial_bit;

    // Purpose: one-hot mask of the bit under trial.
    always_comb trial_bit = {{(RES_BITS-1){1'b0}}, 1'b1} << bit_idx_q;

    // Purpose: code offered to the comparator; zero when idle.
    always_comb trial_code = (state_q == SEQ_IDLE) ? '0 : (sar_q | trial_bit);

    // Purpose: phase, bit index, register, latch and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            bit_idx_q  <= TOP_IDX;
            lead_cnt_q <= LEAD_LOAD;
            sar_q      <= '0;
            result_q   <= '0;
            busy_n     <= 1'b1;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q    <= SEQ_LEAD;
                        bit_idx_q  <= TOP_IDX;
                        lead_cnt_q <= LEAD_LOAD;
                        sar_q      <= '0;
                        busy_n     <= 1'b0;
                    end
                end
                SEQ_LEAD: begin
                    if (lead_cnt_q == '0) state_q <= SEQ_RESOLVE;
                    else                  lead_cnt_q <= lead_cnt_q - 1'b1;
                end
                SEQ_RESOLVE: begin
                    if (bit_idx_q == '0) begin
                        result_q <= sar_q | (cmp_keep ? trial_bit : '0);
                        busy_n   <= 1'b1;
                        state_q  <= SEQ_IDLE;
                    end else begin
                        sar_q[bit_idx_q] <= cmp_keep;
                        bit_idx_q        <= bit_idx_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_byte_mux.sv
// Module: sar_byte_mux
// Steers the latched word onto the data pins. Whole word when hbyte_sel is
// low; with it high the upper bits are copied onto the lowest pins and the
// gap between is driven to zero.
// Assumes RES_BITS - LOW_W <= LOW_W.
module sar_byte_mux #(
    parameter  int RES_BITS = 12,
    parameter  int LOW_W    = 8,
    localparam int HIGH_W   = RES_BITS - LOW_W,
    localparam int MID_W    = LOW_W - HIGH_W
) (
    input  logic                hbyte_sel,
    input  logic [RES_BITS-1:0] word,
    output logic [RES_BITS-1:0] data_out
);

    logic [RES_BITS-1:0] folded;

    // Purpose: build the folded layout; the zero gap exists only if MID_W > 0.
    generate
        if (MID_W > 0) begin : g_gap
            always_comb folded = {word[RES_BITS-1:LOW_W], {MID_W{1'b0}},
                                  word[RES_BITS-1:LOW_W]};
        end else begin : g_nogap
            always_comb folded = {word[RES_BITS-1:LOW_W], word[RES_BITS-1:LOW_W]};
        end
    endgenerate

    // Purpose: pick whole or folded word.
    always_comb data_out = hbyte_sel ? folded : word;

endmodule

// File: rtl/sar_adc_core.sv
// Module: sar_adc_core (top)
// Digital core of a successive-approximation converter: start gating,
// bit sequencing, result latch, byte steering and the inverted clock out.
// Assumes all control inputs are synchronous to clk_in; reset is
// synchronous and active low.
module sar_adc_core #(
    parameter int RES_BITS    = 12,
    parameter int LEAD_CYCLES = 1,
    parameter int LOW_W       = 8
) (
    input  logic                clk_in,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                hbyte_sel,
    input  logic                cmp_keep,
    output logic                clk_out,
    output logic                busy_n,
    output logic [RES_BITS-1:0] trial_code,
    output logic [RES_BITS-1:0] data_out,
    output logic                data_oe
);

    logic                start;
    logic [RES_BITS-1:0] result_q;

    // Purpose: inverted clock for an external resonator or downstream use.
    always_comb clk_out = ~clk_in;

    // Purpose: drive enable for the modelled three-state port.
    always_comb data_oe = ~cs_n & ~rd_n;

    sar_start_gate start_i (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .hbyte_sel (hbyte_sel),
        .idle      (busy_n),
        .start     (start)
    );

    sar_sequencer #(
        .RES_BITS    (RES_BITS),
        .LEAD_CYCLES (LEAD_CYCLES)
    ) seq_i (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .start      (start),
        .cmp_keep   (cmp_keep),
        .busy_n     (busy_n),
        .trial_code (trial_code),
        .result_q   (result_q)
    );

    sar_byte_mux #(
        .RES_BITS (RES_BITS),
        .LOW_W    (LOW_W)
    ) mux_i (
        .hbyte_sel (hbyte_sel),
        .word      (result_q),
        .data_out  (data_out)
    );

endmodule

// File: rtl/sar_adc_core_chk.sv
// Module: sar_adc_core_chk
// Temporal checks on the converter core, bound into every instance.
// Assumes the same parameters as the instance it is bound to.
module sar_adc_core_chk #(
    parameter  int RES_BITS    = 12,
    parameter  int LEAD_CYCLES = 1,
    parameter  int LOW_W       = 8,
    localparam int CONV        = LEAD_CYCLES + RES_BITS,
    localparam int CNT_W       = $clog2(CONV + 2) + 1
) (
    input logic                clk_in,
    input logic                rst_n,
    input logic                cs_n,
    input logic                rd_n,
    input logic                hbyte_sel,
    input logic                busy_n,
    input logic [RES_BITS-1:0] trial_code,
    input logic [RES_BITS-1:0] data_out,
    input logic [RES_BITS-1:0] result_q
);

    logic [CNT_W-1:0] low_cnt;

    // Purpose: count consecutive busy cycles, saturating.
    always_ff @(posedge clk_in) begin
        if (!rst_n || busy_n)           low_cnt <= '0;
        else if (low_cnt != {CNT_W{1'b1}}) low_cnt <= low_cnt + 1'b1;
    end

    a_r3_busy_len: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(busy_n) |-> (low_cnt == CNT_W'(CONV)));

    a_r2_no_stretch: assert property (@(posedge clk_in) disable iff (!rst_n)
        (low_cnt <= CNT_W'(CONV)));

    a_r4_msb_first: assert property (@(posedge clk_in) disable iff (!rst_n)
        $fell(busy_n) |-> (trial_code == {1'b1, {(RES_BITS-1){1'b0}}}));

    a_r7_old_word: assert property (@(posedge clk_in) disable iff (!rst_n)
        !busy_n |-> $stable(result_q));

    a_r9_blocks_start: assert property (@(posedge clk_in) disable iff (!rst_n)
        (hbyte_sel && busy_n) |=> busy_n);

    a_r9_gap_zero: assert property (@(posedge clk_in) disable iff (!rst_n)
        hbyte_sel |-> (data_out[LOW_W-1:RES_BITS-LOW_W] == '0));

    a_r8_whole_word: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!hbyte_sel && !cs_n && !rd_n) |-> (data_out == result_q));

endmodule

bind sar_adc_core sar_adc_core_chk #(
    .RES_BITS    (RES_BITS),
    .LEAD_CYCLES (LEAD_CYCLES),
    .LOW_W       (LOW_W)
) chk_i (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hbyte_sel  (hbyte_sel),
    .busy_n     (busy_n),
    .trial_code (trial_code),
    .data_out   (data_out),
    .result_q   (result_q)
);

// File: tb/sar_adc_core_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for sar_adc_core, one task each.
module sar_adc_core_tb_top;

    localparam real CYC = 5.0;

    logic        clk_in = 1'b0;
    logic        rst_n;
    logic        cs_n, rd_n, hbyte_sel;
    logic        cmp_keep;
    logic        clk_out, busy_n, data_oe;
    logic [11:0] trial_code, data_out;
    logic [11:0] vin;
    int          checks = 0;
    int          fails  = 0;

    always #(CYC/2) clk_in = ~clk_in;

    // Comparator model: keep the trial bit when the input code reaches it.
    assign cmp_keep = (vin >= trial_code);

    sar_adc_core dut_i (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .hbyte_sel  (hbyte_sel),
        .cmp_keep   (cmp_keep),
        .clk_out    (clk_out),
        .busy_n     (busy_n),
        .trial_code (trial_code),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_bus();
        @(negedge clk_in);
        cs_n = 1'b1; rd_n = 1'b1; hbyte_sel = 1'b0;
        repeat (2) @(negedge clk_in);
    endtask

    // R11: reset state, read through the folded port without starting.
    task automatic t_reset_state();
        check("R11", "busy after reset", busy_n, 1'b1);
        @(negedge clk_in);
        cs_n = 1'b0; rd_n = 1'b0; hbyte_sel = 1'b1;
        #1;
        check("R6", "oe with cs and rd low", data_oe, 1'b1);
        check("R11", "latch zero", data_out, 12'h000);
        repeat (4) @(negedge clk_in);
        #1;
        check("R9", "no start while high byte", busy_n, 1'b1);
        check("R11", "trial idle", trial_code, 12'h000);
        idle_bus();
    endtask

    // R3 R4 R5 R7 R1: a full conversion, then a held condition.
    task automatic t_convert(input logic [11:0] v, input logic [11:0] prev);
        int n = 0;
        @(negedge clk_in);
        vin = v; cs_n = 1'b0; rd_n = 1'b0; hbyte_sel = 1'b0;
        #1;
        check("R7", "old word before start", data_out, prev);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_in);
            #1;
            if (!busy_n) begin
                n++;
                if (n == 1) check("R4", "first trial", trial_code, 12'h800);
                if (n == 2) check("R4", "msb not yet decided", trial_code, 12'h800);
                if (n == 3) check("R4", "after msb decision", trial_code,
                                  (v >= 12'h800 ? 12'h800 : 12'h000) | 12'h400);
                if (n == 7) check("R7", "old word mid conversion", data_out, prev);
            end else if (n > 0) begin
                break;
            end
        end
        check("R3", "busy cycles", n, 13);
        check("R5", "result", data_out, v);
        repeat (10) @(negedge clk_in);
        #1;
        check("R1", "held condition no restart", busy_n, 1'b1);
        idle_bus();
    endtask

    // R2: a fresh start edge during a conversion is ignored.
    task automatic t_lockout(input logic [11:0] v);
        int n = 0;
        @(negedge clk_in);
        vin = v; cs_n = 1'b0; rd_n = 1'b0; hbyte_sel = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_in);
            #1;
            if (n == 4) rd_n = 1'b1;
            if (n == 5) rd_n = 1'b0;
            if (!busy_n) n++;
            else if (n > 0) break;
        end
        check("R2", "length kept", n, 13);
        check("R2", "result kept", data_out, v);
        repeat (5) @(negedge clk_in);
        #1;
        check("R2", "no second conversion", busy_n, 1'b1);
        idle_bus();
    endtask

    // R1: partial conditions start nothing.
    task automatic t_partial();
        @(negedge clk_in);
        cs_n = 1'b0; rd_n = 1'b1; hbyte_sel = 1'b0;
        repeat (3) @(negedge clk_in);
        #1;
        check("R1", "cs only", busy_n, 1'b1);
        check("R6", "oe with rd high", data_oe, 1'b0);
        cs_n = 1'b1; rd_n = 1'b0;
        repeat (3) @(negedge clk_in);
        #1;
        check("R1", "rd only", busy_n, 1'b1);
        check("R6", "oe with cs high", data_oe, 1'b0);
        idle_bus();
    endtask

    // R8 R9: byte steering of latched word v; the return to low starts a run.
    task automatic t_bytes(input logic [11:0] v);
        @(negedge clk_in);
        cs_n = 1'b0; rd_n = 1'b0; hbyte_sel = 1'b1;
        #1;
        check("R9", "folded word", data_out, {v[11:8], 4'h0, v[11:8]});
        repeat (3) @(negedge clk_in);
        #1;
        check("R9", "no start on high byte", busy_n, 1'b1);
        hbyte_sel = 1'b0;
        #1;
        check("R8", "whole word", data_out, v);
        repeat (20) @(negedge clk_in);
        #1;
        check("R8", "same input same word", data_out, v);
        idle_bus();
    endtask

    // R10: clock output inversion in both phases.
    task automatic t_clock();
        @(negedge clk_in);
        #1;
        check("R10", "clk low phase", clk_out, 1'b1);
        @(posedge clk_in);
        #1;
        check("R10", "clk high phase", clk_out, 1'b0);
    endtask

    initial begin
        #(CYC * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; hbyte_sel = 1'b0; vin = 12'h000;
        repeat (4) @(negedge clk_in);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_clock();
        t_convert(12'hABC, 12'h000);
        t_convert(12'h7FF, 12'hABC);
        t_convert(12'h000, 12'h7FF);
        t_convert(12'hFFF, 12'h000);
        t_convert(12'h800, 12'hFFF);
        t_lockout(12'h35A);
        t_partial();
        t_bytes(12'h35A);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule